// File: doc/BRIEF.md
# Write-Only Two-Wire Control Receiver

This block receives control bytes over a two-wire serial bus as a slave that can only be written. The system clock oversamples the bus clock and data lines, so the block finds start and stop conditions and clock edges inside its own clock domain. It answers to one fixed 7-bit address and pulls the data line low for acknowledge through an open-drain enable output. The data bytes it receives land in a small bank of control registers. These registers switch individual clock outputs on or off and select a test mode.

A write begins with the address byte (0xD2 for a write). The master then sends two bytes whose values are discarded, the command byte and the count byte, and the block acknowledges each of them. After that, data bytes fill register 0, register 1 and register 2 in that order. There is no subaddress and no readback. To change a later register, the master has to resend every register in front of it.

Top module: `i2cs_ctl_top`

## Requirements
- R1: After reset all three control registers hold 0xFF, so every clock output is enabled and test mode is off, and `sda_oe` is 0.
- R2: A first byte of 0xD2 after a start is acknowledged: `sda_oe` is 1 during the high phase of the ninth bus clock.
- R3: A first byte whose bits 7..1 differ from 1101001, or whose bit 0 (read/write flag) is 1, is not acknowledged. The block then leaves every register unchanged and drives nothing until the next start.
- R4: The two bytes that follow an accepted address (command, then count) are acknowledged, and their values change no register.
- R5: Data bytes are shifted in MSB first, and the first, second and third data bytes are written to registers 0, 1 and 2 respectively.
- R6: Every data byte after the third is acknowledged and discarded.
- R7: `sda_oe` becomes 1 only after a falling bus-clock edge, and it returns to 0 after the falling edge that ends the ninth clock.
- R8: A register takes its new value as soon as all eight bits of its byte have arrived. If a stop follows, only the registers already sent are changed.
- R9: A repeated start restarts the sequence at the address byte. The next byte is judged as an address, and the data that follows fills the registers again from register 0.
- R10: `clk_en[7:0]` is register 0 and `clk_en[15:8]` is register 1. `test_mode` is the inverse of register 2 bit 0, and `aux_cfg` is register 2 bits 7..1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND result) |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| clk_en | output | 16 | Per-output clock enables, registers 1:0 |
| test_mode | output | 1 | Test mode select, active when register 2 bit 0 is 0 |
| aux_cfg | output | 7 | Register 2 bits 7..1 |

## Verification
Full three-byte writes use distinct values in every register, and the command and count bytes carry values that look like data. Together these show MSB-first ordering, register order and that the two header bytes are ignored. Over-long writes, writes cut short by a stop, and writes broken by a repeated start each separate the register-index logic from the byte-position counter. Wrong addresses and read requests check that a refused transfer leaves the registers alone and keeps the acknowledge released. The acknowledge is sampled in the ninth clock and again after its falling edge, so its timing is checked as well as its presence.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // command byte + count byte after the address
  localparam int HDR_BYTES = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_ACK, ST_SKIP} rx_state_t;

  function automatic logic addr_is_write(input logic [7:0] b, input logic [6:0] own);
    return (b[7:1] == own) && !b[0];
  endfunction

  // byte position 0 is the address; data starts after the header bytes
  function automatic logic is_data_slot(input int unsigned pos, input int unsigned nreg);
    return (pos >= 1 + HDR_BYTES) && (pos < 1 + HDR_BYTES + nreg);
  endfunction
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2cs_rx.sv
module i2cs_rx
  import i2cs_pkg::*;
#(
  parameter int         NREG   = 3,
  parameter logic [6:0] ADDR   = 7'h69,
  parameter int         SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              ack_oe,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_idx,
  output logic [7:0]        wr_data
);
  localparam int POS_MAX = 1 + HDR_BYTES + NREG;
  localparam int POS_W   = $clog2(POS_MAX + 1);
  localparam logic [POS_W-1:0] DATA0 = POS_W'(1 + HDR_BYTES);

  rx_state_t        state;
  logic [7:0]       shreg;
  logic [3:0]       bit_cnt;
  logic [POS_W-1:0] pos;
  logic             byte_done;

  assign byte_done = (bit_cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      pos     <= '0;
      ack_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_RECV;
        bit_cnt <= '0;
        pos     <= '0;
        ack_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        ack_oe <= 1'b0;
      end else begin
        case (state)
          ST_RECV: begin
            if (scl_rise && !byte_done) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && byte_done) begin
              bit_cnt <= '0;
              if (pos == '0 && !addr_is_write(shreg, ADDR)) begin
                state <= ST_SKIP;
              end else begin
                state  <= ST_ACK;
                ack_oe <= 1'b1;
                if (is_data_slot(32'(pos), NREG)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= SLOT_W'(pos - DATA0);
                  wr_data <= shreg;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              ack_oe <= 1'b0;
              state  <= ST_RECV;
              if (pos != POS_W'(POS_MAX)) pos <= pos + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe) |-> $past(scl_fall));
  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_oe) |-> $past(scl_fall || start_det || stop_det));
  // R5
  write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ack_oe);
  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !ack_oe && !wr_en);
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
  parameter int NREG   = 3,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_flat[g*8 +: 8] <= 8'hFF;
      else if (wr_en && wr_idx == SLOT_W'(g)) regs_flat[g*8 +: 8] <= wr_data;
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/i2cs_ctl_top.sv
module i2cs_ctl_top #(
  parameter int         NREG      = 3,
  parameter logic [6:0] ADDR      = 7'h69,
  parameter int         SYNC_STG  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 sda_oe,
  output logic [(NREG-1)*8-1:0] clk_en,
  output logic                 test_mode,
  output logic [6:0]           aux_cfg
);
  localparam int SLOT_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_idx;
  logic [7:0]        wr_data;
  logic [NREG*8-1:0] regs_flat;

  i2cs_sync #(.STAGES(SYNC_STG)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_rx #(.NREG(NREG), .ADDR(ADDR), .SLOT_W(SLOT_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ack_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  i2cs_regbank #(.NREG(NREG), .SLOT_W(SLOT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_flat(regs_flat)
  );

  assign clk_en    = regs_flat[(NREG-1)*8-1:0];
  assign test_mode = ~regs_flat[(NREG-1)*8];
  assign aux_cfg   = regs_flat[NREG*8-1 -: 7];
endmodule

// File: tb/i2cs_ctl_top_tb_top.sv
`timescale 1ns/1ps
module i2cs_ctl_top_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, test_mode;
  logic [15:0] clk_en;
  logic [6:0]  aux_cfg;
  wire  sda_line = sda_m & ~sda_oe;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [3];

  always #2 clk = ~clk;

  i2cs_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .clk_en(clk_en), .test_mode(test_mode), .aux_cfg(aux_cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [23:0] regs_seen();
    return {aux_cfg, ~test_mode, clk_en[15:8], clk_en[7:0]};
  endfunction

  task automatic chk_regs(input string req);
    chk(req, {8'h0, regs_seen()}, {8'h0, exp_r[2], exp_r[1], exp_r[0]});
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
    end
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    chk(req, {31'h0, sda_oe}, {31'h0, exp_ack});
    q(); scl_m = 1'b0; q();
    // R7: acknowledge released after the ninth falling edge
    chk("R7", {31'h0, sda_oe}, 32'h0);
  endtask

  task automatic t_reset();
    // R1, R10
    chk("R1", {31'h0, sda_oe}, 32'h0);
    chk("R10", {16'h0, clk_en}, 32'h0000_FFFF);
    chk("R10", {31'h0, test_mode}, 32'h0);
    chk("R10", {25'h0, aux_cfg}, 32'h7F);
  endtask

  task automatic t_full_write();
    bus_start();
    send_byte(8'hD2, 1'b1, "R2");
    send_byte(8'h5A, 1'b1, "R4");
    send_byte(8'h03, 1'b1, "R4");
    chk_regs("R4");
    send_byte(8'h12, 1'b1, "R5");
    send_byte(8'h34, 1'b1, "R5");
    send_byte(8'hFE, 1'b1, "R5");
    bus_stop();
    exp_r[0] = 8'h12; exp_r[1] = 8'h34; exp_r[2] = 8'hFE;
    chk_regs("R5");
    chk("R10", {31'h0, test_mode}, 32'h1);
    chk("R10", {25'h0, aux_cfg}, 32'h7F);
    chk("R10", {16'h0, clk_en}, 32'h3412);
  endtask

  task automatic t_extra();
    bus_start();
    send_byte(8'hD2, 1'b1, "R2");
    send_byte(8'hC3, 1'b1, "R4");
    send_byte(8'hB2, 1'b1, "R4");
    send_byte(8'hA1, 1'b1, "R5");
    send_byte(8'hB2, 1'b1, "R5");
    send_byte(8'hC3, 1'b1, "R5");
    send_byte(8'h00, 1'b1, "R6");
    send_byte(8'h5E, 1'b1, "R6");
    bus_stop();
    exp_r[0] = 8'hA1; exp_r[1] = 8'hB2; exp_r[2] = 8'hC3;
    chk_regs("R6");
  endtask

  task automatic t_bad_addr();
    bus_start();
    send_byte(8'hD4, 1'b0, "R3");
    send_byte(8'h00, 1'b0, "R3");
    send_byte(8'h00, 1'b0, "R3");
    send_byte(8'h00, 1'b0, "R3");
    bus_stop();
    chk_regs("R3");
    bus_start();
    send_byte(8'hD3, 1'b0, "R3");
    send_byte(8'h11, 1'b0, "R3");
    send_byte(8'h22, 1'b0, "R3");
    send_byte(8'h33, 1'b0, "R3");
    bus_stop();
    chk_regs("R3");
  endtask

  task automatic t_partial();
    bus_start();
    send_byte(8'hD2, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h01, 1'b1, "R4");
    send_byte(8'h0F, 1'b1, "R8");
    bus_stop();
    exp_r[0] = 8'h0F;
    chk_regs("R8");
  endtask

  task automatic t_restart();
    bus_start();
    send_byte(8'hD2, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h55, 1'b1, "R9");
    bus_start();
    send_byte(8'hD2, 1'b1, "R9");
    send_byte(8'h99, 1'b1, "R9");
    send_byte(8'h98, 1'b1, "R9");
    send_byte(8'h66, 1'b1, "R9");
    exp_r[0] = 8'h66;
    chk_regs("R9");
    bus_start();
    send_byte(8'h77, 1'b0, "R9");
    send_byte(8'h44, 1'b0, "R9");
    bus_stop();
    chk_regs("R9");
  endtask

  initial begin
    exp_r[0] = 8'hFF; exp_r[1] = 8'hFF; exp_r[2] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_full_write();
    t_extra();
    t_bad_addr();
    t_partial();
    t_restart();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule